// File: doc/BRIEF.md
# Q-format saturating arithmetic unit

This unit performs one arithmetic operation per clock on two signed fixed-point words. Each word is a 16-bit two's complement integer that carries an implied binary point: a sign bit, some integer bits and `FRAC_BITS` fraction bits, so the stored integer stands for that integer times 2^-FRAC_BITS. The number of fraction bits is fixed when the unit is built. It cannot be changed while the unit runs.

A 2-bit selector picks one of four operations: add with wraparound, add with clamping, subtract with wraparound, or multiply. The multiply rounds and clamps its result. Inputs are sampled on every rising clock edge, and the result and a clamp indicator appear on registered outputs one cycle later. The unit holds no state from one operation to the next. A clamped result therefore does not affect any later operation.

Top module: `qfx_alu`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges after it rises, `result` and `sat_flag` read zero.
- R2: Inputs sampled at a rising edge show on `result` and `sat_flag` right after that edge. They do not show earlier.
- R3: Selector 2'b00 returns the low 16 bits of `op_a + op_b`, with wraparound. `sat_flag` is low.
- R4: Selector 2'b01 adds with full precision. A sum above 32767 returns 0x7FFF and a sum below -32768 returns 0x8000, and `sat_flag` goes high in both cases. Any other sum is returned exactly with `sat_flag` low.
- R5: Selector 2'b10 returns the low 16 bits of `op_a - op_b`, with wraparound. `sat_flag` is low.
- R6: Selector 2'b11 forms the exact signed product and adds 2^(FRAC_BITS-1). It then shifts right arithmetically by FRAC_BITS and clamps the result to 0x8000..0x7FFF. `sat_flag` is high exactly when that clamp changes the value.
- R7: In a multiply, a value exactly halfway between two output steps rounds toward positive infinity, for both signs. For example, with 8 fraction bits, -0.5 LSB gives 0 and +0.5 LSB gives 1.
- R8: Clamping is not sticky. A clamping add followed by an add of operands with opposite signs returns the exact sum, with `sat_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 16 | First operand, signed fixed point |
| op_b | input | 16 | Second operand, signed fixed point |
| op_sel | input | 2 | Operation: 00 wrap add, 01 clamping add, 10 wrap subtract, 11 rounded clamping multiply |
| result | output | 16 | Registered result of the operation |
| sat_flag | output | 1 | High when the registered result was clamped |

## Verification
The clocked properties compare each output with the operands and selector that were present one edge earlier. They therefore assume that every input is a defined value at every edge, reset cycles included. They ignore results produced while the internal reset is still held, and the first edge after it. The bench drives every input from its first time step and changes inputs only on falling edges. It holds them steady through each rising edge and starts issuing operations only after the internal reset has been released. Two copies of the unit, one with 8 fraction bits and one with 15, receive identical operands. Each copy is checked against a 64-bit integer model of the rules above.

// File: rtl/qfx_pkg.sv
package qfx_pkg;

  typedef enum logic [1:0] {
    QOP_ADDW = 2'b00,
    QOP_ADDS = 2'b01,
    QOP_SUB  = 2'b10,
    QOP_MUL  = 2'b11
  } qop_e;

endpackage

// File: rtl/qfx_addsub.sv
module qfx_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub_sel,
  input  logic         sat_en,
  output logic [W-1:0] res,
  output logic         clamped
);

  localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  logic signed [W:0] ext_a;
  logic signed [W:0] ext_b;
  logic signed [W:0] sum_full;
  logic              ovf;

  always_comb begin
    ext_a    = {a[W-1], a};
    ext_b    = {b[W-1], b};
    sum_full = sub_sel ? (ext_a - ext_b) : (ext_a + ext_b);
    // the extra bit disagrees with the word's sign bit only when out of range
    ovf      = sum_full[W] ^ sum_full[W-1];
    clamped  = sat_en & ovf;
    if (clamped) begin
      res = sum_full[W] ? MINW : MAXW;
    end else begin
      res = sum_full[W-1:0];
    end
  end

endmodule

// File: rtl/qfx_mul.sv
module qfx_mul #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         clamped
);

  // one guard bit above the full product so the rounding add cannot wrap
  localparam int PW = 2 * W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (FRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = PW'(-(64'sd1 <<< (W - 1)));

  logic signed [PW-1:0] ext_a;
  logic signed [PW-1:0] ext_b;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rounded;
  logic signed [PW-1:0] scaled;

  always_comb begin
    ext_a   = PW'($signed(a));
    ext_b   = PW'($signed(b));
    prod    = ext_a * ext_b;
    rounded = prod + HALF;
    scaled  = rounded >>> FRAC;
    if (scaled > MAXV) begin
      res     = MAXV[W-1:0];
      clamped = 1'b1;
    end else if (scaled < MINV) begin
      res     = MINV[W-1:0];
      clamped = 1'b1;
    end else begin
      res     = scaled[W-1:0];
      clamped = 1'b0;
    end
  end

endmodule

// File: rtl/qfx_alu.sv
module qfx_alu
  import qfx_pkg::*;
#(
  parameter int W         = 16,
  parameter int FRAC_BITS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         sat_flag
);

  localparam logic [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  generate
    if (FRAC_BITS < 1 || FRAC_BITS > W - 1) begin : g_bad_frac
      $error("FRAC_BITS out of range");
    end
  endgenerate

  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  qop_e op;
  assign op = qop_e'(op_sel);

  logic [W-1:0] as_res;
  logic         as_clamp;
  logic [W-1:0] mul_res;
  logic         mul_clamp;

  qfx_addsub #(.W(W)) u_addsub (
    .a       (op_a),
    .b       (op_b),
    .sub_sel (op == QOP_SUB),
    .sat_en  (op == QOP_ADDS),
    .res     (as_res),
    .clamped (as_clamp)
  );

  qfx_mul #(.W(W), .FRAC(FRAC_BITS)) u_mul (
    .a       (op_a),
    .b       (op_b),
    .res     (mul_res),
    .clamped (mul_clamp)
  );

  logic [W-1:0] nxt_result;
  logic         nxt_flag;
  logic         load_en;
  logic         res_live;

  always_comb begin
    load_en = 1'b1;
    if (op == QOP_MUL) begin
      nxt_result = mul_res;
      nxt_flag   = mul_clamp;
    end else begin
      nxt_result = as_res;
      nxt_flag   = as_clamp;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      result   <= '0;
      sat_flag <= 1'b0;
      res_live <= 1'b0;
    end else if (load_en) begin
      result   <= nxt_result;
      sat_flag <= nxt_flag;
      res_live <= 1'b1;
    end
  end

  // a raised flag always carries one of the two limits (R4, R6)
  p_clamp_limit_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    sat_flag |-> (result == MAXW || result == MINW));

  p_no_flag_wrap_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (res_live && $past(op_sel) == QOP_ADDW) |-> !sat_flag);

  p_no_flag_sub_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (res_live && $past(op_sel) == QOP_SUB) |-> !sat_flag);

  p_clamp_side_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (res_live && sat_flag && $past(op_sel) == QOP_ADDS)
      |-> (result == ($past(op_a[W-1]) ? MINW : MAXW)));

  p_mixed_sign_exact_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (res_live && $past(op_sel) == QOP_ADDS && ($past(op_a[W-1]) != $past(op_b[W-1])))
      |-> (!sat_flag && result == W'($past(op_a) + $past(op_b))));

  p_mul_zero_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (res_live && $past(op_sel) == QOP_MUL && $past(op_a) == '0)
      |-> (result == '0 && !sat_flag));

endmodule

// File: tb/test_qfx_alu.sv
module test_qfx_alu;

  logic        clk;
  logic        rst_n;
  logic [15:0] op_a;
  logic [15:0] op_b;
  logic [1:0]  op_sel;
  logic [15:0] res8;
  logic        flag8;
  logic [15:0] res15;
  logic        flag15;

  int n_checks;
  int n_errors;
  bit done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  qfx_alu #(.W(16), .FRAC_BITS(8)) i_qfx_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(res8), .sat_flag(flag8)
  );

  qfx_alu #(.W(16), .FRAC_BITS(15)) i_qfx_alu_q15 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .result(res15), .sat_flag(flag15)
  );

  function automatic void ref_op(input logic [15:0] a, input logic [15:0] b,
                                 input logic [1:0] op, input int q,
                                 output logic [15:0] r, output logic f);
    longint sa, sb, v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    f  = 1'b0;
    case (op)
      2'b00: v = sa + sb;
      2'b10: v = sa - sb;
      2'b01: begin
        v = sa + sb;
        if (v > 32767)  begin v = 32767;  f = 1'b1; end
        if (v < -32768) begin v = -32768; f = 1'b1; end
      end
      default: begin
        v = (sa * sb + (64'sd1 <<< (q - 1))) >>> q;
        if (v > 32767)  begin v = 32767;  f = 1'b1; end
        if (v < -32768) begin v = -32768; f = 1'b1; end
      end
    endcase
    r = v[15:0];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] got_r, input logic got_f,
                       input logic [15:0] exp_r, input logic exp_f);
    n_checks++;
    if (got_r !== exp_r || got_f !== exp_f) begin
      n_errors++;
      $display("FAIL %s %s: got result=%h flag=%b, expected result=%h flag=%b",
               tag, what, got_r, got_f, exp_r, exp_f);
    end
  endtask

  // drive on a falling edge, check both widths on the next falling edge
  task automatic do_op(input string tag, input logic [15:0] a,
                       input logic [15:0] b, input logic [1:0] op);
    logic [15:0] e8, e15;
    logic f8, f15;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op;
    ref_op(a, b, op, 8, e8, f8);
    ref_op(a, b, op, 15, e15, f15);
    @(negedge clk);
    check(tag, "q8", res8, flag8, e8, f8);
    check(tag, "q15", res15, flag15, e15, f15);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    op_a = 16'h7FFF; op_b = 16'h7FFF; op_sel = 2'b11;
    repeat (3) @(negedge clk);
    check("R1", "in reset q8", res8, flag8, 16'h0000, 1'b0);
    check("R1", "in reset q15", res15, flag15, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "sync release q8", res8, flag8, 16'h0000, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wrap_add;
    do_op("R3", 16'h1234, 16'h0101, 2'b00);
    do_op("R3", 16'h7000, 16'h2000, 2'b00);
    do_op("R3", 16'h8000, 16'hFFFF, 2'b00);
  endtask

  task automatic t_sat_add;
    do_op("R4", 16'h7000, 16'h2000, 2'b01);
    do_op("R4", 16'h9000, 16'h9000, 2'b01);
    do_op("R4", 16'h7FFF, 16'h0001, 2'b01);
    do_op("R4", 16'h0100, 16'hFF00, 2'b01);
    do_op("R4", 16'h3FFF, 16'h4000, 2'b01);
  endtask

  task automatic t_sub;
    do_op("R5", 16'h8000, 16'h0001, 2'b10);
    do_op("R5", 16'h0005, 16'h0009, 2'b10);
  endtask

  task automatic t_mul;
    do_op("R6", 16'h0180, 16'h0200, 2'b11);
    do_op("R6", 16'hFE80, 16'h0300, 2'b11);
    do_op("R6", 16'h7FFF, 16'h7FFF, 2'b11);
    do_op("R6", 16'h8000, 16'h8000, 2'b11);
    do_op("R6", 16'h8000, 16'h7FFF, 2'b11);
  endtask

  task automatic t_round;
    do_op("R7", 16'h0080, 16'h0001, 2'b11);
    do_op("R7", 16'hFF80, 16'h0001, 2'b11);
    do_op("R7", 16'h0040, 16'h0200, 2'b11);
    do_op("R7", 16'hFFC0, 16'h0200, 2'b11);
  endtask

  task automatic t_nonsticky;
    do_op("R8", 16'h7FFF, 16'h0100, 2'b01);
    do_op("R8", 16'h7FFF, 16'hFF00, 2'b01);
    do_op("R8", 16'h8000, 16'hFFFF, 2'b01);
    do_op("R8", 16'h8000, 16'h0010, 2'b01);
  endtask

  task automatic t_latency;
    logic [15:0] prev8;
    logic [15:0] e8;
    logic f8;
    do_op("R2", 16'h0011, 16'h0022, 2'b00);
    prev8 = res8;
    @(negedge clk);
    op_a = 16'h0100; op_b = 16'h0001; op_sel = 2'b10;
    #2;
    check("R2", "before edge q8", res8, flag8, prev8, 1'b0);
    ref_op(16'h0100, 16'h0001, 2'b10, 8, e8, f8);
    @(posedge clk);
    #1;
    check("R2", "after edge q8", res8, flag8, e8, f8);
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    t_reset();
    t_wrap_add();
    t_sat_add();
    t_sub();
    t_mul();
    t_round();
    t_nonsticky();
    t_latency();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule